// File: doc/BRIEF.md
# Shift-Register Ring Slave Node

This block is one segment of a serial ring made of shift registers. The master opens and closes the ring. The node sits between an incoming and an outgoing serial line. Each bit strobe moves the ring by one position. At the start of a cycle the node loads a word into its shift path. In a data cycle that word comes from the local application. In an identification cycle it is a fixed identification code. While the stream passes through, the word travels toward the master, and the bits arriving from upstream take its place.

After the payload, the master switches the node into its check phase. The shift register then holds still, and the ring runs through a separate 16-bit frame-check path. This path captures a 16-bit CRC field and then a 16-bit control word. Throughout the payload the node keeps its own CRC of the incoming bits. When the cycle ends, the node checks three things: its CRC matches the received field, exactly 32 check bits arrived, and the update flag in the control word is set. Only if all three hold does it hand the received word to the application. A data cycle delivers it to the output word; an identification cycle delivers it to a control word.

The ring has no stall mechanism, so the serial side carries a strobe but no ready. The node cannot apply back-pressure, and the application must take each result pulse on the cycle it appears. The parallel input word is sampled only on the cycle-start clock.

Top module: `ring_slave_node`

## Requirements
- R1: While reset is held and after it is released, `line_out`, `out_word` and `ctl_word` are zero, and `out_vld`, `ctl_vld` and `chk_fail` are low.
- R2: A `cyc_start` with `cyc_ident`=0 loads `in_word` into the shift register. On the following payload strobes, `line_out` presents that word most significant bit first. A later change of `in_word` has no effect on the cycle.
- R3: A `cyc_start` with `cyc_ident`=1 loads the `ID_CODE` parameter into the shift register in place of `in_word`, and it is sent most significant bit first.
- R4: In the payload phase (`fcs_sel`=0), the bit sampled on `line_in` at strobe k is the value of `line_out` when strobe k+DW is applied.
- R5: In the check phase (`fcs_sel`=1), the data shift register holds its contents. The frame-check path is cleared at `cyc_start`, so its first 16 outputs are zero, and after that it delays `line_in` by 16 strobes.
- R6: The CRC is seeded to 0xFFFF at `cyc_start` and covers every payload-phase bit in arrival order. It uses polynomial 0x1021 (x^16+x^12+x^5+1), most significant bit first. It is compared with the first 16 check-phase bits, which are received most significant bit first.
- R7: At the clock that samples `cyc_end` of a data cycle, if the CRC matches, exactly 32 check bits were received, and bit 0 of the control word is 1, then `out_word` takes the last DW payload bits received and `out_vld` is high for exactly one cycle. The control word is check bits 16 to 31, so bit 0 is the last check bit.
- R8: In an identification cycle, the same conditions update `ctl_word` and pulse `ctl_vld` instead, and `out_word` stays unchanged.
- R9: At `cyc_end`, a CRC mismatch or a check-bit count other than 32 pulses `chk_fail` for one cycle and leaves `out_word` and `ctl_word` unchanged.
- R10: A valid check with bit 0 of the control word at 0 produces no pulse and leaves both words unchanged.
- R11: A clock with no strobe leaves the shift contents unchanged, so `line_out` holds its value and the stream resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_start | input | 1 | Opens a cycle: parallel load, CRC seed, check path clear |
| cyc_ident | input | 1 | Cycle kind at `cyc_start`: 0 data, 1 identification |
| fcs_sel | input | 1 | 0 routes the ring through the data register, 1 through the frame-check path |
| cyc_end | input | 1 | Closes the cycle and triggers the check |
| line_vld | input | 1 | Bit strobe of the serial ring |
| line_in | input | 1 | Incoming serial bit |
| line_out | output | 1 | Outgoing serial bit |
| in_word | input | DW | Application word sent toward the master |
| out_vld | output | 1 | One-cycle pulse: `out_word` updated |
| out_word | output | DW | Received data for the application |
| ctl_vld | output | 1 | One-cycle pulse: `ctl_word` updated |
| ctl_word | output | DW | Word received in an identification cycle |
| chk_fail | output | 1 | One-cycle pulse: frame check failed |

## Verification
The serial output is checked combinationally, one nanosecond after each strobe is driven on a falling edge. The expected bit is worked out from the loaded word for the first DW strobes, and from the stream delayed by DW strobes (or 16 in the check phase) after that. Result pulses appear on the rising edge that samples `cyc_end`. The driver queues the expected outcome before it raises `cyc_end`, and the monitor pops and compares on the next falling edge. Cycles that must leave the words unchanged are followed by a read of both words two clocks later.

// File: rtl/ring_node_pkg.sv
package ring_node_pkg;
  localparam int          CRC_W     = 16;
  localparam logic [15:0] CRC_POLY  = 16'h1021;
  localparam logic [15:0] CRC_SEED  = 16'hFFFF;
  localparam int          FCS_BITS  = 2 * CRC_W;

  typedef enum logic {
    CYC_DATA  = 1'b0,
    CYC_IDENT = 1'b1
  } cyc_kind_e;

  typedef enum logic [1:0] {
    RES_NONE,
    RES_DATA,
    RES_CTRL,
    RES_FAIL
  } res_e;
endpackage

// File: rtl/ring_node_crc.sv
module ring_node_crc #(
  parameter int         W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021,
  parameter logic [W-1:0] SEED = 16'hFFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic feedback;
  assign feedback = crc[W-1] ^ din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc <= SEED;
    else if (seed) crc <= SEED;
    else if (en)   crc <= {crc[W-2:0], 1'b0} ^ (feedback ? POLY : '0);
  end
endmodule

// File: rtl/ring_node_shreg.sv
module ring_node_shreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/ring_node_fcs.sv
module ring_node_fcs #(
  parameter int W          = 16,
  parameter int FRAME_BITS = 32,
  parameter int UPD_BIT    = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         en,
  input  logic         din,
  input  logic [W-1:0] crc_calc,
  output logic         msb,
  output logic         upd_flag,
  output logic         crc_match,
  output logic         len_ok
);
  localparam int               CNT_W     = $clog2(FRAME_BITS + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] CRC_LAST  = CNT_W'(W - 1);
  localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(FRAME_BITS);

  logic [W-1:0]     sr;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     sr_next;

  assign sr_next = {sr[W-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '0;
      cnt       <= '0;
      crc_match <= 1'b0;
    end else if (clear) begin
      sr        <= '0;
      cnt       <= '0;
      crc_match <= 1'b0;
    end else if (en) begin
      sr <= sr_next;
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      if (cnt == CRC_LAST) crc_match <= (sr_next == crc_calc);
    end
  end

  assign msb      = sr[W-1];
  assign upd_flag = sr[UPD_BIT];
  assign len_ok   = (cnt == FRAME_END);
endmodule

// File: rtl/ring_slave_node.sv
module ring_slave_node
  import ring_node_pkg::*;
#(
  parameter int            DW      = 16,
  parameter logic [DW-1:0] ID_CODE = 16'hA5C3,
  parameter int            UPD_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_start,
  input  logic          cyc_ident,
  input  logic          fcs_sel,
  input  logic          cyc_end,
  input  logic          line_vld,
  input  logic          line_in,
  output logic          line_out,
  input  logic [DW-1:0] in_word,
  output logic          out_vld,
  output logic [DW-1:0] out_word,
  output logic          ctl_vld,
  output logic [DW-1:0] ctl_word,
  output logic          chk_fail
);
  cyc_kind_e      kind_q;
  logic [DW-1:0]  load_val;
  logic [DW-1:0]  data_q;
  logic [CRC_W-1:0] crc_q;
  logic           dat_shift;
  logic           fcs_shift;
  logic           fcs_msb;
  logic           upd_flag;
  logic           crc_match;
  logic           len_ok;
  res_e           res_d;

  assign load_val  = cyc_ident ? ID_CODE : in_word;
  assign dat_shift = line_vld & ~fcs_sel & ~cyc_start;
  assign fcs_shift = line_vld &  fcs_sel & ~cyc_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         kind_q <= CYC_DATA;
    else if (cyc_start) kind_q <= cyc_ident ? CYC_IDENT : CYC_DATA;
  end

  ring_node_shreg #(.W(DW)) u_data (
    .clk(clk), .rst_n(rst_n), .load(cyc_start), .load_val(load_val),
    .shift(dat_shift), .din(line_in), .q(data_q)
  );

  ring_node_crc #(.W(CRC_W), .POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
    .clk(clk), .rst_n(rst_n), .seed(cyc_start), .en(dat_shift),
    .din(line_in), .crc(crc_q)
  );

  ring_node_fcs #(.W(CRC_W), .FRAME_BITS(FCS_BITS), .UPD_BIT(UPD_BIT)) u_fcs (
    .clk(clk), .rst_n(rst_n), .clear(cyc_start), .en(fcs_shift),
    .din(line_in), .crc_calc(crc_q), .msb(fcs_msb), .upd_flag(upd_flag),
    .crc_match(crc_match), .len_ok(len_ok)
  );

  assign line_out = fcs_sel ? fcs_msb : data_q[DW-1];

  always_comb begin
    res_d = RES_NONE;
    if (cyc_end) begin
      if (!(crc_match && len_ok)) res_d = RES_FAIL;
      else if (upd_flag)          res_d = (kind_q == CYC_DATA) ? RES_DATA : RES_CTRL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      ctl_vld  <= 1'b0;
      chk_fail <= 1'b0;
      out_word <= '0;
      ctl_word <= '0;
    end else begin
      out_vld  <= (res_d == RES_DATA);
      ctl_vld  <= (res_d == RES_CTRL);
      chk_fail <= (res_d == RES_FAIL);
      if (res_d == RES_DATA) out_word <= data_q;
      if (res_d == RES_CTRL) ctl_word <= data_q;
    end
  end
endmodule

// File: rtl/ring_node_chk.sv
module ring_node_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cyc_start,
  input logic          fcs_sel,
  input logic          cyc_end,
  input logic          line_vld,
  input logic          line_out,
  input logic          out_vld,
  input logic [DW-1:0] out_word,
  input logic          ctl_vld,
  input logic [DW-1:0] ctl_word,
  input logic          chk_fail
);
  AST_OUT_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> !out_vld); // R7
  AST_CTL_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_vld |=> !ctl_vld); // R8
  AST_RESULT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_vld, ctl_vld, chk_fail})); // R9
  AST_RESULT_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld || ctl_vld || chk_fail) |-> $past(cyc_end)); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> $stable(out_word)); // R10
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_vld |-> $stable(ctl_word)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(line_vld) && !$past(cyc_start) && $stable(fcs_sel)) |-> $stable(line_out)); // R11
endmodule

bind ring_slave_node ring_node_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .fcs_sel(fcs_sel),
  .cyc_end(cyc_end), .line_vld(line_vld), .line_out(line_out),
  .out_vld(out_vld), .out_word(out_word), .ctl_vld(ctl_vld),
  .ctl_word(ctl_word), .chk_fail(chk_fail)
);

// File: tb/sim_ring_slave_node.sv
module sim_ring_slave_node;
  localparam int          CLK_PERIOD = 10;
  localparam int          DW         = 16;
  localparam logic [15:0] ID_VAL     = 16'hA5C3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc_start = 0, cyc_ident = 0, fcs_sel = 0, cyc_end = 0;
  logic line_vld = 0, line_in = 0;
  logic line_out, out_vld, ctl_vld, chk_fail;
  logic [DW-1:0] in_word = '0, out_word, ctl_word;

  int n_cmp = 0, n_bad = 0;
  int exp_kind[$];
  logic [15:0] exp_word[$];
  logic [15:0] last_out = '0, last_ctl = '0;
  logic [31:0] lcg = 32'h1357_9BDF;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_slave_node #(.DW(DW), .ID_CODE(ID_VAL), .UPD_BIT(0)) u0 (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_ident(cyc_ident),
    .fcs_sel(fcs_sel), .cyc_end(cyc_end), .line_vld(line_vld), .line_in(line_in),
    .line_out(line_out), .in_word(in_word), .out_vld(out_vld), .out_word(out_word),
    .ctl_vld(ctl_vld), .ctl_word(ctl_word), .chk_fail(chk_fail)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    crc_step = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

  // monitor: pops the scoreboard whenever a result pulse appears
  always @(negedge clk) begin
    if (rst_n && (out_vld || ctl_vld || chk_fail)) begin
      int kind;
      logic [15:0] w;
      kind = out_vld ? 1 : (ctl_vld ? 2 : 3);
      w    = out_vld ? out_word : (ctl_vld ? ctl_word : 16'h0);
      if (exp_kind.size() == 0) check("R9 unexpected pulse", 32'(kind), 32'd0);
      else begin
        int ek;
        logic [15:0] ew;
        ek = exp_kind.pop_front();
        ew = exp_word.pop_front();
        check("R7/R8/R9 result kind", 32'(kind), 32'(ek));
        check("R7/R8 result word", {16'h0, w}, {16'h0, ew});
      end
    end
  end

  // driver: one full ring cycle
  task automatic run_cycle(input bit ident, input logic [15:0] word, input int nbits,
                           input int gap, input bit bad_crc, input logic [15:0] ctrl,
                           input int fcs_len);
    logic bits[$];
    logic [15:0] crc, loaded, tail;
    logic [31:0] fcs;
    logic exp_bit, held;
    bit good;
    loaded = ident ? ID_VAL : word;
    crc = 16'hFFFF;
    for (int i = 0; i < nbits; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      bits.push_back(lcg[16]);
      crc = crc_step(crc, lcg[16]);
    end
    fcs = {bad_crc ? (crc ^ 16'h0100) : crc, ctrl};
    for (int k = 0; k < 16; k++) tail[15-k] = bits[nbits-16+k];

    @(negedge clk);
    cyc_start = 1; cyc_ident = ident; in_word = word;
    @(negedge clk);
    cyc_start = 0; in_word = ~word;
    for (int i = 0; i < nbits; i++) begin
      if (gap > 0 && i == 4) begin
        line_vld = 0; #1; held = line_out;
        repeat (gap) begin
          @(negedge clk); #1;
          check("R11 hold without strobe", 32'(line_out), 32'(held));
        end
      end
      line_vld = 1; line_in = bits[i]; #1;
      exp_bit = (i < 16) ? loaded[15-i] : bits[i-16];
      if (i < 16) check(ident ? "R3 id code out" : "R2 input word out", 32'(line_out), 32'(exp_bit));
      else        check("R4 payload delay", 32'(line_out), 32'(exp_bit));
      @(negedge clk);
    end
    fcs_sel = 1;
    for (int j = 0; j < fcs_len; j++) begin
      line_vld = 1; line_in = (j < 32) ? fcs[31-j] : 1'b0; #1;
      exp_bit = (j < 16) ? 1'b0 : fcs[31-(j-16)];
      check("R5 check path", 32'(line_out), 32'(exp_bit));
      @(negedge clk);
    end
    line_vld = 0;
    good = !bad_crc && (fcs_len == 32);
    if (!good) begin exp_kind.push_back(3); exp_word.push_back(16'h0); end
    else if (ctrl[0]) begin
      exp_kind.push_back(ident ? 2 : 1); exp_word.push_back(tail);
      if (ident) last_ctl = tail; else last_out = tail;
    end
    cyc_end = 1;
    @(negedge clk);
    cyc_end = 0; fcs_sel = 0; #1;
    check("R5 data register frozen", 32'(line_out), 32'(tail[15]));
    repeat (2) @(negedge clk);
    check("R9/R10 out_word kept", {16'h0, out_word}, {16'h0, last_out});
    check("R9/R10 ctl_word kept", {16'h0, ctl_word}, {16'h0, last_ctl});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 line_out in reset", 32'(line_out), 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 line_out", 32'(line_out), 32'd0);
    check("R1 out_word", {16'h0, out_word}, 32'd0);
    check("R1 ctl_word", {16'h0, ctl_word}, 32'd0);
    check("R1 pulses", {29'd0, out_vld, ctl_vld, chk_fail}, 32'd0);

    run_cycle(0, 16'h3C5A, 48, 0, 0, 16'h0001, 32); // R2 R4 R6 R7 commit
    run_cycle(1, 16'h1111, 32, 0, 0, 16'h8001, 32); // R3 R8 ident commit
    run_cycle(0, 16'hF00F, 40, 3, 0, 16'h0003, 32); // R11 gap, R7 commit
    run_cycle(0, 16'h0F0F, 32, 0, 1, 16'h0001, 32); // R6 R9 bad CRC
    run_cycle(0, 16'h1234, 32, 0, 0, 16'hFFFE, 32); // R10 no update bit
    run_cycle(0, 16'h5555, 32, 0, 0, 16'h0001, 31); // R9 short check field
    run_cycle(0, 16'hAAAA, 32, 0, 0, 16'h0001, 33); // R9 long check field
    run_cycle(0, 16'hFFFF, 16, 0, 0, 16'h0001, 32); // R7 payload exactly DW
    run_cycle(1, 16'h0000, 24, 2, 0, 16'h4001, 32); // R3 R8 R11

    repeat (3) @(negedge clk);
    check("R7 scoreboard drained", 32'(exp_kind.size()), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule